// File: doc/BRIEF.md
# Recursive Invertible-Set Write Encoder

This block prepares one data word for a memory whose cells may be permanently stuck at 0 or at 1. The word is viewed as a grid of `ROWS` by `COLS` cells. Bit `r*COLS + c` of every word-wide port is the cell in row `r` and column `c`. A start strobe captures the data word and a fault map. The fault map is a stuck mask plus the stuck values, and it stands in for a write-verify readback. The block then works one pass per clock. It decides which cells must be written inverted, so that every cell reads back correctly once the inversion rule is applied.

Each row and each column has a small saturating counter. The first pass marks every row and column that holds a cell whose stuck value disagrees with the bit to be written. The marked rows crossed with the marked columns form a mesh, and the counters of that mesh are raised by one. A cell is written inverted when the smaller of its row and column counters is odd. Each later pass looks only inside the current mesh. Inversion has turned some correct stuck cells into wrong ones, so the block marks those, shrinks the mesh, and raises its counters again. This repeats until no wrong cell remains.

Encoding gives up with a failure in two cases: when a pass fails to shrink the mesh, which means the faults form an alternately stuck loop, or when a counter would have to pass its capacity. A reader decodes a cell by XOR-ing its readback with the parity of the minimum of its row and column counters.

Top module: `ris_encoder`

## Requirements
- R1: After reset, `done`, `fail`, every counter and `phys_out` are 0.
- R2: With no stuck cells, `done` rises one clock after `start` is sampled. `fail` is 0, every counter is 0 and `phys_out` equals `data_in`.
- R3: On a successful encode, for every cell, the readback XOR-ed with bit 0 of min(row counter, column counter) equals the captured data bit. The readback is the stuck value where `stuck_mask` is 1 and the `phys_out` bit otherwise.
- R4: The block performs one pass per clock. A single wrong stuck cell at row `r`, column `c` finishes two clocks after start. Row counter `r` and column counter `c` are then 1 and all others are 0. Counter `i` occupies bits `[i*COUNT_W +: COUNT_W]`.
- R5: The mesh is nested. In a 4x4 grid, take cell (0,0) stuck wrong, (1,1) stuck wrong and (0,1) stuck right. This encodes in three clocks and ends with row counters {2,1,0,0} and column counters {1,2,0,0}. A counter only ever clears to 0 or steps up by 1.
- R6: Take the loop (0,0) and (1,1) stuck wrong, (0,1) and (1,0) stuck right. `done` and `fail` rise together two clocks after start, with counters of rows 0,1 and columns 0,1 at 1.
- R7: The capacity of a counter is 2^COUNT_W-1. If a pass would raise a counter beyond it, the block ends with `done` and `fail` and leaves the counters unchanged.
- R8: With `COUNT_W` of 2 or more, any pattern of at most three stuck cells encodes with `fail` low.
- R9: While an encode runs, `start` is ignored and changes on `data_in`, `stuck_mask` and `stuck_val` have no effect. The inputs are captured only when `start` is accepted.
- R10: Accepting `start` clears every counter and clears `fail`.
- R11: `done` is a one-clock pulse. `fail` holds its value after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an encode; accepted only when idle |
| data_in | input | ROWS*COLS | Word to protect |
| stuck_mask | input | ROWS*COLS | 1 where a cell is stuck |
| stuck_val | input | ROWS*COLS | Value a stuck cell holds |
| phys_out | output | ROWS*COLS | Word to write to the array |
| row_cnt | output | ROWS*COUNT_W | Row counters, row i at [i*COUNT_W +: COUNT_W] |
| col_cnt | output | COLS*COUNT_W | Column counters, column i at [i*COUNT_W +: COUNT_W] |
| done | output | 1 | One-clock pulse at the end of an encode |
| fail | output | 1 | Encode could not mask the faults |

## Verification
The main instance is a 4x4 grid with 2-bit counters. At that size the hand-worked cases can be run: a clean word, a single fault, the nested three-fault case, the alternately stuck loop, and many random three-fault patterns that the capacity of 3 must always absorb. A second instance is a 2x8 grid with 1-bit counters. With a capacity of 1, the nested three-fault case runs into the counter limit on its second pass, and the non-square layout checks the row-major bit numbering.

// File: rtl/ris_pkg.sv
package ris_pkg;

   typedef enum logic {
      ENC_IDLE,
      ENC_PASS
   } enc_state_e;

   typedef struct packed {
      logic any_wrong;
      logic no_shrink;
      logic at_cap;
   } pass_flags_t;

endpackage

// File: rtl/ris_cell_eval.sv
module ris_cell_eval #(
   parameter int ROWS    = 4,
   parameter int COLS    = 4,
   parameter int COUNT_W = 2,
   localparam int NCELL  = ROWS * COLS
) (
   input  logic [NCELL-1:0]        data,
   input  logic [NCELL-1:0]        smask,
   input  logic [NCELL-1:0]        sval,
   input  logic [ROWS*COUNT_W-1:0] rcnt,
   input  logic [COLS*COUNT_W-1:0] ccnt,
   output logic [NCELL-1:0]        wr_word,
   output logic [NCELL-1:0]        wrong
);

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int IDX = r * COLS + c;
         logic [COUNT_W-1:0] rc, cc;
         logic inv;
         assign rc = rcnt[r*COUNT_W +: COUNT_W];
         assign cc = ccnt[c*COUNT_W +: COUNT_W];
         if (COUNT_W == 1) begin : g_bit
            assign inv = rc[0] & cc[0];
         end else begin : g_cmp
            assign inv = (rc < cc) ? rc[0] : cc[0];
         end
         assign wr_word[IDX] = data[IDX] ^ inv;
         assign wrong[IDX]   = smask[IDX] & (sval[IDX] != wr_word[IDX]);
      end
   end

endmodule

// File: rtl/ris_mesh_reduce.sv
module ris_mesh_reduce #(
   parameter int ROWS   = 4,
   parameter int COLS   = 4,
   localparam int NCELL = ROWS * COLS
) (
   input  logic [NCELL-1:0] wrong,
   input  logic [ROWS-1:0]  mesh_rows,
   input  logic [COLS-1:0]  mesh_cols,
   output logic [ROWS-1:0]  new_rows,
   output logic [COLS-1:0]  new_cols,
   output logic             any_wrong,
   output logic             no_shrink
);

   logic [ROWS-1:0][COLS-1:0] hit;
   logic [COLS-1:0][ROWS-1:0] hit_t;

   for (genvar r = 0; r < ROWS; r++) begin : g_r
      for (genvar c = 0; c < COLS; c++) begin : g_c
         assign hit[r][c]   = wrong[r*COLS+c] & mesh_rows[r] & mesh_cols[c];
         assign hit_t[c][r] = hit[r][c];
      end
      assign new_rows[r] = |hit[r];
   end

   for (genvar c = 0; c < COLS; c++) begin : g_cr
      assign new_cols[c] = |hit_t[c];
   end

   assign any_wrong = |new_rows;
   assign no_shrink = (new_rows == mesh_rows) && (new_cols == mesh_cols);

endmodule

// File: rtl/ris_counter_bank.sv
module ris_counter_bank #(
   parameter int N_CTR   = 4,
   parameter int COUNT_W = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     inc,
   input  logic [N_CTR-1:0]         sel,
   output logic [N_CTR*COUNT_W-1:0] cnt_flat,
   output logic                     at_cap
);

   localparam logic [COUNT_W-1:0] CAP = '1;

   logic [N_CTR-1:0] cap_hit;

   for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
      logic [COUNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (clr)
            cnt_q <= '0;
         else if (inc && sel[i])
            cnt_q <= cnt_q + COUNT_W'(1);
      end
      assign cap_hit[i] = sel[i] && (cnt_q == CAP);
      assign cnt_flat[i*COUNT_W +: COUNT_W] = cnt_q;
   end

   assign at_cap = |cap_hit;

endmodule

// File: rtl/ris_encoder.sv
module ris_encoder #(
   parameter int ROWS    = 4,
   parameter int COLS    = 4,
   parameter int COUNT_W = 2,
   localparam int NCELL  = ROWS * COLS
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [NCELL-1:0]         data_in,
   input  logic [NCELL-1:0]         stuck_mask,
   input  logic [NCELL-1:0]         stuck_val,
   output logic [NCELL-1:0]         phys_out,
   output logic [ROWS*COUNT_W-1:0]  row_cnt,
   output logic [COLS*COUNT_W-1:0]  col_cnt,
   output logic                     done,
   output logic                     fail
);
   import ris_pkg::*;

   if (ROWS < 2) begin : g_bad_rows
      $error("ris_encoder: ROWS must be at least 2");
   end
   if (COLS < 2) begin : g_bad_cols
      $error("ris_encoder: COLS must be at least 2");
   end
   if (COUNT_W < 1 || COUNT_W > 8) begin : g_bad_cw
      $error("ris_encoder: COUNT_W must be 1..8");
   end

   enc_state_e       state_q;
   logic [NCELL-1:0] data_q, mask_q, val_q, phys_q;
   logic [ROWS-1:0]  mesh_rows_q, new_rows;
   logic [COLS-1:0]  mesh_cols_q, new_cols;
   logic             first_q, done_q, fail_q;
   logic [NCELL-1:0] wr_word, wrong;
   logic             row_cap, col_cap;
   pass_flags_t      pf;
   logic             accept, halt_bad, inc_en;

   ris_cell_eval #(.ROWS(ROWS), .COLS(COLS), .COUNT_W(COUNT_W)) u_eval (
      .data   (data_q),
      .smask  (mask_q),
      .sval   (val_q),
      .rcnt   (row_cnt),
      .ccnt   (col_cnt),
      .wr_word(wr_word),
      .wrong  (wrong)
   );

   ris_mesh_reduce #(.ROWS(ROWS), .COLS(COLS)) u_mesh (
      .wrong    (wrong),
      .mesh_rows(mesh_rows_q),
      .mesh_cols(mesh_cols_q),
      .new_rows (new_rows),
      .new_cols (new_cols),
      .any_wrong(pf.any_wrong),
      .no_shrink(pf.no_shrink)
   );

   assign accept   = (state_q == ENC_IDLE) && start;
   assign pf.at_cap = row_cap | col_cap;
   assign halt_bad = (!first_q && pf.no_shrink) || pf.at_cap;
   assign inc_en   = (state_q == ENC_PASS) && pf.any_wrong && !halt_bad;

   ris_counter_bank #(.N_CTR(ROWS), .COUNT_W(COUNT_W)) u_rows (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept),
      .inc     (inc_en),
      .sel     (new_rows),
      .cnt_flat(row_cnt),
      .at_cap  (row_cap)
   );

   ris_counter_bank #(.N_CTR(COLS), .COUNT_W(COUNT_W)) u_cols (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept),
      .inc     (inc_en),
      .sel     (new_cols),
      .cnt_flat(col_cnt),
      .at_cap  (col_cap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ENC_IDLE;
         data_q      <= '0;
         mask_q      <= '0;
         val_q       <= '0;
         phys_q      <= '0;
         mesh_rows_q <= '0;
         mesh_cols_q <= '0;
         first_q     <= 1'b0;
         done_q      <= 1'b0;
         fail_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ENC_IDLE: begin
               if (start) begin
                  data_q      <= data_in;
                  mask_q      <= stuck_mask;
                  val_q       <= stuck_val;
                  mesh_rows_q <= '1;
                  mesh_cols_q <= '1;
                  first_q     <= 1'b1;
                  fail_q      <= 1'b0;
                  state_q     <= ENC_PASS;
               end
            end
            ENC_PASS: begin
               if (!pf.any_wrong || halt_bad) begin
                  done_q  <= 1'b1;
                  fail_q  <= pf.any_wrong;
                  phys_q  <= wr_word;
                  state_q <= ENC_IDLE;
               end else begin
                  mesh_rows_q <= new_rows;
                  mesh_cols_q <= new_cols;
                  first_q     <= 1'b0;
               end
            end
            default: state_q <= ENC_IDLE;
         endcase
      end
   end

   assign phys_out = phys_q;
   assign done     = done_q;
   assign fail     = fail_q;

endmodule

// File: rtl/ris_encoder_chk.sv
module ris_encoder_chk #(
   parameter int ROWS    = 4,
   parameter int COLS    = 4,
   parameter int COUNT_W = 2,
   localparam int NCELL  = ROWS * COLS
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    done,
   input logic                    fail,
   input logic [NCELL-1:0]        phys_out,
   input logic [ROWS*COUNT_W-1:0] row_cnt,
   input logic [COLS*COUNT_W-1:0] col_cnt,
   input logic [NCELL-1:0]        data_q,
   input logic [NCELL-1:0]        mask_q,
   input logic [NCELL-1:0]        val_q
);

   logic [NCELL-1:0] cell_ok;

   for (genvar r = 0; r < ROWS; r++) begin : g_r
      for (genvar c = 0; c < COLS; c++) begin : g_c
         localparam int IDX = r * COLS + c;
         logic [COUNT_W-1:0] rc, cc, mn;
         logic rb;
         assign rc = row_cnt[r*COUNT_W +: COUNT_W];
         assign cc = col_cnt[c*COUNT_W +: COUNT_W];
         assign mn = (rc < cc) ? rc : cc;
         assign rb = mask_q[IDX] ? val_q[IDX] : phys_out[IDX];
         assign cell_ok[IDX] = ((rb ^ mn[0]) == data_q[IDX]);
      end
   end

   // R3: a successful encode decodes back to the captured word
   assert_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fail) |-> (&cell_ok));

   // R11: done lasts one clock
   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6 / R7: fail rises only together with done
   assert_fail_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> done);

   // R5: counters clear or step by one
   for (genvar i = 0; i < ROWS; i++) begin : g_rs
      assert_row_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(row_cnt[i*COUNT_W +: COUNT_W]) |->
            (row_cnt[i*COUNT_W +: COUNT_W] == '0) ||
            (row_cnt[i*COUNT_W +: COUNT_W] == $past(row_cnt[i*COUNT_W +: COUNT_W]) + COUNT_W'(1)));
   end
   for (genvar i = 0; i < COLS; i++) begin : g_cs
      assert_col_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(col_cnt[i*COUNT_W +: COUNT_W]) |->
            (col_cnt[i*COUNT_W +: COUNT_W] == '0) ||
            (col_cnt[i*COUNT_W +: COUNT_W] == $past(col_cnt[i*COUNT_W +: COUNT_W]) + COUNT_W'(1)));
   end

endmodule

bind ris_encoder ris_encoder_chk #(.ROWS(ROWS), .COLS(COLS), .COUNT_W(COUNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .done    (done),
   .fail    (fail),
   .phys_out(phys_out),
   .row_cnt (row_cnt),
   .col_cnt (col_cnt),
   .data_q  (data_q),
   .mask_q  (mask_q),
   .val_q   (val_q)
);

// File: tb/ris_encoder_tb.sv
module ris_encoder_tb;
   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [15:0] data, mask, val;
      bit          exp_fail;
      int          lat;
      bit          chk_cnt;
      logic [7:0]  rc, cc;
      bit          chk_phys;
      logic [15:0] phys;
      string       req;
      int          t0;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0;
   logic [15:0] data_in = '0, stuck_mask = '0, stuck_val = '0;
   logic [15:0] phys_out;
   logic [7:0]  row_cnt, col_cnt;
   logic        done, fail;

   logic        s_start = 1'b0;
   logic [15:0] s_data = '0, s_mask = '0, s_val = '0, s_phys;
   logic [1:0]  s_rc;
   logic [7:0]  s_cc;
   logic        s_done, s_fail;

   int checks = 0, errors = 0, cyc = 0;
   item_t sb[$];
   bit    post_chk = 1'b0;
   logic  post_fail;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ris_encoder #(.ROWS(4), .COLS(4), .COUNT_W(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
      .stuck_mask(stuck_mask), .stuck_val(stuck_val), .phys_out(phys_out),
      .row_cnt(row_cnt), .col_cnt(col_cnt), .done(done), .fail(fail));

   ris_encoder #(.ROWS(2), .COLS(8), .COUNT_W(1)) u_dut_small (
      .clk(clk), .rst_n(rst_n), .start(s_start), .data_in(s_data),
      .stuck_mask(s_mask), .stuck_val(s_val), .phys_out(s_phys),
      .row_cnt(s_rc), .col_cnt(s_cc), .done(s_done), .fail(s_fail));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit decodes(input logic [15:0] d, m, v, p, input logic [7:0] rc, cc);
      for (int r = 0; r < 4; r++)
         for (int c = 0; c < 4; c++) begin
            logic [1:0] a, b, mn;
            logic rb;
            a  = rc[r*2 +: 2];
            b  = cc[c*2 +: 2];
            mn = (a < b) ? a : b;
            rb = m[r*4+c] ? v[r*4+c] : p[r*4+c];
            if ((rb ^ mn[0]) != d[r*4+c]) return 1'b0;
         end
      return 1'b1;
   endfunction

   // monitor: pop expected item on each done pulse
   always @(negedge clk) begin
      if (post_chk) begin
         post_chk = 1'b0;
         chk(!done, "R11", "done lasts one clock", done, 0);
         chk(fail === post_fail, "R11", "fail held after done", fail, post_fail);
      end
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R9", "unexpected done", 1, 0);
         end else begin
            item_t it;
            it = sb.pop_front();
            chk(fail === it.exp_fail, it.req, "fail", fail, it.exp_fail);
            if (it.lat >= 0)
               chk(cyc - it.t0 == it.lat, it.req, "latency", cyc - it.t0, it.lat);
            if (it.chk_cnt) begin
               chk(row_cnt === it.rc, it.req, "row counters", row_cnt, it.rc);
               chk(col_cnt === it.cc, it.req, "col counters", col_cnt, it.cc);
            end
            if (it.chk_phys)
               chk(phys_out === it.phys, it.req, "phys word", phys_out, it.phys);
            if (!it.exp_fail)
               chk(decodes(it.data, it.mask, it.val, phys_out, row_cnt, col_cnt),
                   "R3", "decode of readback", phys_out, it.data);
            post_fail = fail;
            post_chk  = 1'b1;
         end
      end
   end

   task automatic drive(input logic [15:0] d, m, v, input bit ef, input int lat,
                        input bit cc_en, input logic [7:0] rc, cc,
                        input bit ph_en, input logic [15:0] ph,
                        input string req, input bit poke_busy);
      item_t it;
      @(negedge clk);
      data_in = d; stuck_mask = m; stuck_val = v; start = 1'b1;
      it.data = d; it.mask = m; it.val = v; it.exp_fail = ef; it.lat = lat;
      it.chk_cnt = cc_en; it.rc = rc; it.cc = cc; it.chk_phys = ph_en; it.phys = ph;
      it.req = req; it.t0 = cyc + 1;
      sb.push_back(it);
      @(negedge clk);
      if (poke_busy) begin
         // R9: start and input changes while busy
         data_in = ~d; stuck_mask = 16'hFFFF; stuck_val = 16'h0F0F; start = 1'b1;
         @(negedge clk);
      end
      start = 1'b0; data_in = 16'h0; stuck_mask = 16'h0; stuck_val = 16'h0;
      while (sb.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R1", "watchdog expired", cyc, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!done && !fail, "R1", "done/fail after reset", {done, fail}, 0);
      chk(row_cnt == 0 && col_cnt == 0, "R1", "counters after reset", {row_cnt, col_cnt}, 0);
      chk(phys_out == 0, "R1", "phys after reset", phys_out, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2: clean word
      drive(16'hA5C3, 16'h0, 16'h0, 0, 1, 1, 8'h00, 8'h00, 1, 16'hA5C3, "R2", 0);
      // R4: single wrong cell at (1,2), bit 6
      drive(16'hA5C3, 16'h0040, 16'h0000, 0, 2, 1, 8'h04, 8'h10, 0, 0, "R4", 0);
      // R5: nested three-fault case
      drive(16'hA5C3, 16'h0023, 16'h0022, 0, 3, 1, 8'h06, 8'h09, 0, 0, "R5", 0);
      // R6: alternately stuck loop
      drive(16'hA5C3, 16'h0033, 16'h0022, 1, 2, 1, 8'h05, 8'h05, 0, 0, "R6", 0);
      // R10: counters and fail cleared by next start
      drive(16'h1234, 16'h0, 16'h0, 0, 1, 1, 8'h00, 8'h00, 1, 16'h1234, "R10", 0);
      // R9: start and input change during the nested case are ignored
      drive(16'hA5C3, 16'h0023, 16'h0022, 0, 3, 1, 8'h06, 8'h09, 0, 0, "R9", 1);
      // stuck-right-only cell: no pass needed
      drive(16'h00FF, 16'h0001, 16'h0001, 0, 1, 1, 8'h00, 8'h00, 1, 16'h00FF, "R2", 0);

      // R8: random patterns of three stuck cells
      for (int t = 0; t < 60; t++) begin
         int p0, p1, p2;
         logic [15:0] m;
         p0 = $urandom_range(0, 15);
         do p1 = $urandom_range(0, 15); while (p1 == p0);
         do p2 = $urandom_range(0, 15); while (p2 == p0 || p2 == p1);
         m = (16'h1 << p0) | (16'h1 << p1) | (16'h1 << p2);
         drive(16'($urandom), m, 16'($urandom), 0, -1, 0, 8'h0, 8'h0, 0, 0, "R8", 0);
      end

      // R7: capacity 1 on the 2x8 instance, same nested pattern (bits 0,1,9)
      begin
         int t0;
         @(negedge clk);
         s_data = 16'hA5C3; s_mask = 16'h0203; s_val = 16'h0202; s_start = 1'b1;
         t0 = cyc + 1;
         @(negedge clk);
         s_start = 1'b0;
         while (!s_done && cyc - t0 < 20) @(negedge clk);
         chk(s_done && s_fail, "R7", "capacity halt done/fail", {s_done, s_fail}, 2'b11);
         chk(cyc - t0 == 2, "R7", "capacity halt latency", cyc - t0, 2);
         chk(s_rc == 2'b11, "R7", "row counters kept", s_rc, 2'b11);
         chk(s_cc == 8'h03, "R7", "col counters kept", s_cc, 8'h03);
         // R4 on the non-square grid: wrong cell at (1,6), bit 14
         @(negedge clk);
         s_data = 16'h4000; s_mask = 16'h4000; s_val = 16'h0000; s_start = 1'b1;
         t0 = cyc + 1;
         @(negedge clk);
         s_start = 1'b0;
         while (!s_done && cyc - t0 < 20) @(negedge clk);
         chk(s_done && !s_fail, "R4", "2x8 single fault done", {s_done, s_fail}, 2'b10);
         chk(cyc - t0 == 2, "R4", "2x8 single fault latency", cyc - t0, 2);
         chk(s_rc == 2'b10 && s_cc == 8'h40, "R4", "2x8 counters", {s_rc, s_cc}, {2'b10, 8'h40});
         chk(s_phys == 16'h0000, "R3", "2x8 inverted cell", s_phys, 16'h0000);
      end

      repeat (3) @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule